// File: doc/BRIEF.md
# DRAM Self-Refresh Timing Engine

This block keeps a DRAM array refreshed on its own while the device sits in a low-power state. It wakes up when power-down is entered, or when nap is entered with the self-refresh enable bit set. From then on, a free-running time-base tick paces the work. Each interval it opens one bank/row with an activate strobe. A fixed number of clocks later it closes that bank/row with a precharge strobe. It then steps its bank and row counters.

The counters are the same ones used by command-driven refresh, so progress carries across low-power episodes. The bank counter runs in plain binary order, and the row counter moves on each time the bank counter wraps. When the low-power state ends, a refresh that is still open is finished with its precharge. The block then drops its busy flag and returns the bank counter to zero, so the controller can take refresh back from bank zero. The row counter keeps its value and remains readable.

Top module: `srefresh_engine`

## Requirements
- R1: Asserting `pdn_i` while idle sets `busy_o` on the next clock, whatever the value of `nap_sr_en_i`, and refreshes then follow.
- R2: Nap (`nap_i`=1, `pdn_i`=0) starts self-refresh only when `nap_sr_en_i`=1. With the enable at 0, `busy_o` stays 0 and no activate is issued.
- R3: While active, `act_o` pulses exactly once every `INTERVAL_TICKS` pulses of `tick_i`. With a tick every D clocks, consecutive activates are `INTERVAL_TICKS`*D clocks apart.
- R4: Each activate presents the bank counter on `ref_bank_o` and the row counter on `ref_row_o`. The bank counter then steps by one in binary order (0,1,2,...,max).
- R5: When the bank counter wraps from its maximum (all ones) to 0, the row counter increments by one. The row counter wraps from all ones to 0.
- R6: `pre_o` pulses exactly `TRAS_CYC` clocks after `act_o`, with the same bank/row on `ref_bank_o`/`ref_row_o`. No second activate comes before that precharge. The counters advance on the clock edge that raises `pre_o`.
- R7: If the low-power request is removed while a bank/row is open, the precharge is still issued on schedule. `busy_o` falls on the same edge that raises `pre_o`, and no further activate follows.
- R8: On every return to idle, `bank_cnt_o` reads 0 and `row_cnt_o` keeps its value.
- R9: After reset, `busy_o`, `act_o`, `pre_o`, `bank_cnt_o` and `row_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_i | input | 1 | Device is in power-down |
| nap_i | input | 1 | Device is in nap |
| nap_sr_en_i | input | 1 | Self-refresh enable for nap |
| tick_i | input | 1 | Single-cycle pulse from the internal time base |
| act_o | output | 1 | Activate strobe, one cycle |
| pre_o | output | 1 | Precharge strobe, one cycle |
| ref_bank_o | output | BANK_W | Bank of the current refresh |
| ref_row_o | output | ROW_W | Row of the current refresh |
| bank_cnt_o | output | BANK_W | Bank counter register |
| row_cnt_o | output | ROW_W | Row counter register |
| busy_o | output | 1 | Self-refresh engine is running or draining |

## Verification
The hardest case to reach is leaving the low-power state while a bank/row is open. That window lasts only `TRAS_CYC` clocks in each refresh interval. The bench waits until it sees the activate strobe and removes power-down in that same cycle. It then confirms that the precharge still comes on time and carries the same address. It also checks that busy falls with the precharge, and that the bank counter reads zero while the row is kept. A second exit is taken between refreshes, and a long power-down run forces the row counter through its own wrap.

// File: rtl/srefresh_pkg.sv
// Shared types for the self-refresh engine.
package srefresh_pkg;

    // Sequencer states: idle, waiting for the interval, row open.
    typedef enum logic [1:0] {
        SR_IDLE = 2'd0,
        SR_WAIT = 2'd1,
        SR_OPEN = 2'd2
    } sr_state_t;

endpackage

// File: rtl/sr_interval_timer.sv
// Interval timer: counts time-base ticks while running and flags every
// INTERVAL_TICKS-th tick. Assumes tick_i is a single-cycle pulse.
module sr_interval_timer #(
    parameter int INTERVAL_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic fire_o
);
    localparam int CW = $clog2(INTERVAL_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Tick counter; held at zero while stopped so each session starts fresh.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Interval boundary.
    always_comb fire_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/sr_addr_counter.sv
// Bank/row counter pair. The bank counter steps in binary order, and the row
// counter steps when the bank counter wraps. clr_bank_i zeroes the bank
// counter and takes precedence over stepping for that counter only.
module sr_addr_counter #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              clr_bank_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam logic [BANK_W-1:0] BANK_MAX = '1;

    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;

    // Bank counter: clear on hand-back, otherwise step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_bank_i) begin
            bank_q <= '0;
        end else if (adv_i) begin
            bank_q <= bank_q + 1'b1;
        end
    end

    // Row counter: step when the bank counter rolls over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (adv_i && (bank_q == BANK_MAX)) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign bank_o = bank_q;
    assign row_o  = row_q;
endmodule

// File: rtl/sr_sequencer.sv
// Refresh sequencer: enters service on a low-power request, issues an
// activate at each interval boundary, and issues a precharge TRAS_CYC clocks
// later. It drains an open row before going idle. Assumes the interval is
// longer than TRAS_CYC clocks, so no boundary falls while a row is open.
module sr_sequencer
    import srefresh_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int ROW_W    = 2,
    parameter int TRAS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              fire_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic              run_o,
    output logic              adv_o,
    output logic              clr_bank_o,
    output logic              act_o,
    output logic              pre_o,
    output logic [BANK_W-1:0] ref_bank_o,
    output logic [ROW_W-1:0]  ref_row_o
);
    localparam int RW = $clog2(TRAS_CYC + 1);
    localparam logic [RW-1:0] RAS_LAST = RW'(TRAS_CYC - 1);

    sr_state_t         state_q;
    logic [RW-1:0]     ras_q;
    logic              ras_done;

    // End of the open-row window.
    always_comb ras_done = (state_q == SR_OPEN) && (ras_q == RAS_LAST);

    // Counter strobes: advance at precharge, clear bank on any return to idle.
    always_comb begin
        adv_o      = ras_done;
        clr_bank_o = !req_i && ((state_q == SR_WAIT) || ras_done);
        run_o      = (state_q != SR_IDLE);
    end

    // State, open-row timer, strobes and latched refresh address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SR_IDLE;
            ras_q      <= '0;
            act_o      <= 1'b0;
            pre_o      <= 1'b0;
            ref_bank_o <= '0;
            ref_row_o  <= '0;
        end else begin
            act_o <= 1'b0;
            pre_o <= 1'b0;
            unique case (state_q)
                SR_IDLE: begin
                    if (req_i) state_q <= SR_WAIT;
                end
                SR_WAIT: begin
                    if (!req_i) begin
                        state_q <= SR_IDLE;
                    end else if (fire_i) begin
                        state_q    <= SR_OPEN;
                        ras_q      <= '0;
                        act_o      <= 1'b1;
                        ref_bank_o <= bank_i;
                        ref_row_o  <= row_i;
                    end
                end
                SR_OPEN: begin
                    if (ras_done) begin
                        pre_o   <= 1'b1;
                        state_q <= req_i ? SR_WAIT : SR_IDLE;
                    end else begin
                        ras_q <= ras_q + 1'b1;
                    end
                end
                default: state_q <= SR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srefresh_engine.sv
// Self-refresh engine top. It forms the low-power request (power-down, or
// nap with enable) and wires the interval timer, the sequencer and the
// shared bank/row counters together. Assumes tick_i is a clean single-cycle
// pulse and that INTERVAL_TICKS ticks span more than TRAS_CYC clocks.
module srefresh_engine #(
    parameter int BANK_W         = 2,
    parameter int ROW_W          = 2,
    parameter int INTERVAL_TICKS = 4,
    parameter int TRAS_CYC       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_i,
    input  logic              nap_i,
    input  logic              nap_sr_en_i,
    input  logic              tick_i,
    output logic              act_o,
    output logic              pre_o,
    output logic [BANK_W-1:0] ref_bank_o,
    output logic [ROW_W-1:0]  ref_row_o,
    output logic [BANK_W-1:0] bank_cnt_o,
    output logic [ROW_W-1:0]  row_cnt_o,
    output logic              busy_o
);
    logic sr_req;
    logic run;
    logic fire;
    logic adv;
    logic clr_bank;

    // Low-power request: power-down always, nap only when enabled.
    always_comb sr_req = pdn_i || (nap_i && nap_sr_en_i);

    sr_interval_timer #(
        .INTERVAL_TICKS(INTERVAL_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick_i),
        .fire_o (fire)
    );

    sr_addr_counter #(
        .BANK_W(BANK_W),
        .ROW_W (ROW_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .clr_bank_i (clr_bank),
        .bank_o     (bank_cnt_o),
        .row_o      (row_cnt_o)
    );

    sr_sequencer #(
        .BANK_W  (BANK_W),
        .ROW_W   (ROW_W),
        .TRAS_CYC(TRAS_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (sr_req),
        .fire_i     (fire),
        .bank_i     (bank_cnt_o),
        .row_i      (row_cnt_o),
        .run_o      (run),
        .adv_o      (adv),
        .clr_bank_o (clr_bank),
        .act_o      (act_o),
        .pre_o      (pre_o),
        .ref_bank_o (ref_bank_o),
        .ref_row_o  (ref_row_o)
    );

    // Busy whenever the sequencer is out of idle.
    assign busy_o = run;
endmodule

// File: rtl/srefresh_engine_chk.sv
// Port-level checker for the self-refresh engine, bound to every instance.
// It tracks the open row and the clocks elapsed since its activate.
module srefresh_engine_chk #(
    parameter int BANK_W   = 2,
    parameter int ROW_W    = 2,
    parameter int TRAS_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pdn_i,
    input logic              nap_i,
    input logic              nap_sr_en_i,
    input logic              act_o,
    input logic              pre_o,
    input logic [BANK_W-1:0] ref_bank_o,
    input logic [ROW_W-1:0]  ref_row_o,
    input logic [BANK_W-1:0] bank_cnt_o,
    input logic [ROW_W-1:0]  row_cnt_o,
    input logic              busy_o
);
    localparam logic [BANK_W-1:0] BMAX = '1;
    localparam int SW = $clog2(TRAS_CYC + 2) + 1;

    logic          open_q;
    logic [SW-1:0] since_q;

    // Open-row flag and clocks since the last activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            since_q <= '0;
        end else if (act_o) begin
            open_q  <= 1'b1;
            since_q <= SW'(1);
        end else if (pre_o) begin
            open_q  <= 1'b0;
        end else if (open_q && since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_PDN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_i && !busy_o |=> busy_o); // R1

    AST_ACT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> $past(pdn_i || (nap_i && nap_sr_en_i))); // R1

    AST_NAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        nap_i && !nap_sr_en_i && !pdn_i && !busy_o |=> !busy_o); // R2

    AST_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pre_o && busy_o && (ref_bank_o != BMAX) |-> bank_cnt_o == ref_bank_o + 1'b1); // R4

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pre_o && (ref_bank_o == BMAX) |-> (row_cnt_o == ROW_W'(ref_row_o + 1'b1)) && (bank_cnt_o == '0)); // R5

    AST_PRE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        pre_o |-> open_q && (since_q == SW'(TRAS_CYC))); // R6

    AST_ONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> !open_q); // R6

    AST_DRAINED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !pre_o |-> !open_q); // R7

    AST_IDLE_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> bank_cnt_o == '0); // R8
endmodule

bind srefresh_engine srefresh_engine_chk #(
    .BANK_W  (BANK_W),
    .ROW_W   (ROW_W),
    .TRAS_CYC(TRAS_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdn_i       (pdn_i),
    .nap_i       (nap_i),
    .nap_sr_en_i (nap_sr_en_i),
    .act_o       (act_o),
    .pre_o       (pre_o),
    .ref_bank_o  (ref_bank_o),
    .ref_row_o   (ref_row_o),
    .bank_cnt_o  (bank_cnt_o),
    .row_cnt_o   (row_cnt_o),
    .busy_o      (busy_o)
);

// File: tb/srefresh_engine_bench.sv
// Scoreboard bench: the driver pushes expected refresh addresses, and the
// monitor pops them on each activate and checks precharge timing and spacing.
module srefresh_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W     = 2;
    localparam int ROW_W      = 2;
    localparam int INTERVAL   = 4;
    localparam int TRAS       = 3;
    localparam int TICK_DIV   = 2;
    localparam int SPACING    = INTERVAL * TICK_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_i = 1'b0, nap_i = 1'b0, nap_sr_en_i = 1'b0, tick_i = 1'b0;
    logic act_o, pre_o, busy_o;
    logic [BANK_W-1:0] ref_bank_o, bank_cnt_o;
    logic [ROW_W-1:0]  ref_row_o, row_cnt_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int act_seen = 0;
    int pre_seen = 0;
    int last_act = 0;
    int act_cyc = 0;
    bit prev_ok = 1'b0;
    int tdiv = 0;
    logic [BANK_W+ROW_W-1:0] exp_q[$];
    logic [BANK_W+ROW_W-1:0] open_addr = '0;
    logic [BANK_W-1:0] m_bank = '0;
    logic [ROW_W-1:0]  m_row = '0;

    srefresh_engine #(
        .BANK_W(BANK_W), .ROW_W(ROW_W),
        .INTERVAL_TICKS(INTERVAL), .TRAS_CYC(TRAS)
    ) u_srefresh_engine (
        .clk(clk), .rst_n(rst_n), .pdn_i(pdn_i), .nap_i(nap_i),
        .nap_sr_en_i(nap_sr_en_i), .tick_i(tick_i), .act_o(act_o),
        .pre_o(pre_o), .ref_bank_o(ref_bank_o), .ref_row_o(ref_row_o),
        .bank_cnt_o(bank_cnt_o), .row_cnt_o(row_cnt_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Time base: one tick every TICK_DIV clocks.
    always @(negedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_i <= (tdiv == TICK_DIV - 1);
    end

    // Monitor: pops expected addresses on activate, checks precharge and spacing.
    always @(negedge clk) begin
        logic [BANK_W+ROW_W-1:0] exp;
        cyc++;
        if (!busy_o) prev_ok = 1'b0;
        if (act_o) begin
            act_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected activate", int'({ref_bank_o, ref_row_o}), -1);
            end else begin
                exp = exp_q.pop_front();
                check({ref_bank_o, ref_row_o} == exp, "R4 R5 refresh address",
                      int'({ref_bank_o, ref_row_o}), int'(exp));
            end
            if (prev_ok) check(cyc - last_act == SPACING, "R3 activate spacing",
                               cyc - last_act, SPACING);
            last_act  = cyc;
            prev_ok   = 1'b1;
            act_cyc   = cyc;
            open_addr = {ref_bank_o, ref_row_o};
        end
        if (pre_o) begin
            pre_seen++;
            check(cyc - act_cyc == TRAS, "R6 precharge delay", cyc - act_cyc, TRAS);
            check({ref_bank_o, ref_row_o} == open_addr, "R6 precharge address",
                  int'({ref_bank_o, ref_row_o}), int'(open_addr));
        end
    end

    // Driver: push the next n expected refreshes from the bench model.
    task automatic expect_refresh(input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({m_bank, m_row});
            if (m_bank == '1) m_row = m_row + 1'b1;
            m_bank = m_bank + 1'b1;
        end
    endtask

    task automatic wait_acts(input int target);
        int t = 0;
        while (act_seen < target && t < 2000) begin
            @(negedge clk); #1; t++;
        end
        check(act_seen >= target, "R3 activates arrive", act_seen, target);
    endtask

    task automatic wait_pres(input int target);
        int t = 0;
        while (pre_seen < target && t < 2000) begin
            @(negedge clk); #1; t++;
        end
        check(pre_seen >= target, "R6 precharges arrive", pre_seen, target);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R9 reset state
        check(busy_o == 0 && act_o == 0 && pre_o == 0, "R9 reset strobes", busy_o, 0);
        check(bank_cnt_o == 0 && row_cnt_o == 0, "R9 reset counters",
              int'({bank_cnt_o, row_cnt_o}), 0);

        // R2: nap without enable stays idle
        nap_i = 1'b1; nap_sr_en_i = 1'b0;
        idle(40);
        check(busy_o == 0, "R2 nap without enable busy", busy_o, 0);
        check(act_seen == 0, "R2 nap without enable activates", act_seen, 0);
        nap_i = 1'b0;

        // R1: power-down starts regardless of the enable bit
        expect_refresh(6);
        pdn_i = 1'b1;
        idle(1);
        check(busy_o == 1, "R1 power-down entry busy", busy_o, 1);
        wait_acts(6);
        // R7: exit while row is open, in the activate cycle
        pdn_i = 1'b0;
        m_bank = '0;
        check(busy_o == 1, "R7 busy while draining", busy_o, 1);
        wait_pres(6);
        check(busy_o == 0, "R7 busy falls with precharge", busy_o, 0);
        idle(30);
        check(act_seen == 6, "R7 no activate after exit", act_seen, 6);
        check(bank_cnt_o == 0, "R8 bank cleared after drain", bank_cnt_o, 0);
        check(row_cnt_o == 1, "R8 row kept after drain", row_cnt_o, 1);

        // R2: nap with enable resumes from bank 0, row kept
        expect_refresh(5);
        nap_i = 1'b1; nap_sr_en_i = 1'b1;
        wait_acts(11);
        wait_pres(11);
        idle(1);
        nap_i = 1'b0;   // exit between refreshes
        m_bank = '0;
        idle(1);
        check(busy_o == 0, "R8 idle after exit between refreshes", busy_o, 0);
        check(bank_cnt_o == 0, "R8 bank cleared on exit", bank_cnt_o, 0);
        check(row_cnt_o == 2, "R5 row advanced at wrap", row_cnt_o, 2);

        // R5: long power-down run through the row wrap
        expect_refresh(9);
        pdn_i = 1'b1;
        wait_acts(20);
        wait_pres(20);
        idle(1);
        pdn_i = 1'b0;
        m_bank = '0;
        idle(3);
        check(row_cnt_o == 0, "R5 row wraps to zero", row_cnt_o, 0);
        check(bank_cnt_o == 0, "R8 bank cleared after wrap run", bank_cnt_o, 0);
        check(exp_q.size() == 0, "R4 all expected refreshes seen", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule